// File: doc/BRIEF.md
# Counted-Enable Interrupt Source Aggregator

This block collects a set of level-sensitive interrupt inputs, each tied to a fixed vector code, and drives one interrupt line toward a processor. A source is gated by more than one register: a bit-per-source mask register, a priority register that gives each source a multi-bit field, and a group register whose bits each enable a whole set of member sources at once. Every source keeps a running count of how many of the fields that cover it are currently enabled. The source may raise an interrupt only when that count reaches its fixed maximum and its input is high.

The mask and group registers each have two write addresses. One ORs the data in and the other clears the bits that are 1 in the data. The priority register is written directly. A read returns the stored value of the addressed register. The processor line is driven by a two-state line machine. In state LINE_IDLE no source is pending. The transition RAISE moves it to LINE_ACTIVE when at least one source becomes pending, and the transition DROP returns it to LINE_IDLE when none is left. Next to the line, the block reports the vector of the lowest-indexed pending source with a valid flag. The report is suppressed while the processor's interrupt mask level is at its top value.

Top module: `irq_source_aggregator`

## Requirements
- R1: After reset, all registers read 0, `cpu_irq` is 0, `vec_valid` is 0 and `vec_code` is 0.
- R2: A write to address 0x0 ORs `bus_wdata[N_SRC-1:0]` into the mask register. Source i is enabled by mask bit N_SRC-1-i. Reads of 0x0 or 0x1 return the mask register, zero-extended.
- R3: A write to address 0x1 clears the mask bits that are 1 in the data (new = old AND NOT data). All other mask bits are kept.
- R4: A write to address 0x2 stores the data as the priority register. Source i owns field [(N_SRC-1-i)*FIELD_W +: FIELD_W], so source 0 holds the top field. A field going from zero to nonzero raises that source's enable count and a field going from nonzero to zero lowers it. A change from one nonzero value to another has no effect on pending state. Reads of 0x2 return the register.
- R5: Address 0x3 ORs and address 0x4 clears the group register, using the same rules as R2 and R3. Group g sits at bit N_GRP-1-g. With the default map, group 0 covers sources 4 and 5 and group 1 covers sources 6 and 7. Reads of 0x3 or 0x4 return the group register.
- R6: A source is pending exactly when its input is high and every covering field is enabled: its mask bit is 1, its priority field is nonzero, and every group containing it is set. Its enable count never exceeds its maximum, which is 2 plus its group memberships.
- R7: `cpu_irq` is high in the cycle after any source is pending and low in the cycle after none is. An input change is registered first, so the line changes two clock edges after the input changes.
- R8: When `vec_valid` is 1, `vec_code` equals VEC_BASE + i*VEC_STEP for the lowest-indexed pending source i (default 0x400 + 0x20*i). `vec_valid` is 1 only while `cpu_irq` is 1.
- R9: While `imask` equals 15, `vec_valid` and `vec_code` are 0 on the next cycle. `cpu_irq` is not affected by `imask`.
- R10: Addresses 0x5 and above read 0, and a write to them changes no register and no output.
- R11: A register write takes effect at the clock edge where it is sampled. `cpu_irq` and the vector reflect the write one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | N_SRC | Level-sensitive source inputs, bit i = source i |
| bus_addr | input | ADDR_W | Register word address |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the addressed register (combinational) |
| imask | input | 4 | Processor interrupt mask level |
| cpu_irq | output | 1 | Interrupt line to the processor |
| vec_code | output | VEC_W | Vector of the selected pending source |
| vec_valid | output | 1 | Vector is meaningful |

## Verification
The bench drives priority fields from one nonzero value to another. A design that counted such writes as enables would push a source past its maximum, and that source would never become pending again. It uses the clear address to drop one mask bit among many. A design that wrote the data instead of AND-NOT would wipe out the other enables, and the lowest pending vector would move to the wrong source. It sets and clears groups over sources that are otherwise enabled, writes to unmapped addresses, and holds `imask` at 15 with sources pending. Each of these exposes a miscount, a stray register update, or a vector that leaks through while masked. Random writes, inputs and mask levels are compared against a model that ANDs every covering field directly, so any drift in the counters shows up as a wrong line or vector.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    typedef enum logic [0:0] {
        LINE_IDLE   = 1'b0,
        LINE_ACTIVE = 1'b1
    } line_state_e;

    localparam logic [3:0] ADR_MASK_OR  = 4'h0;
    localparam logic [3:0] ADR_MASK_CLR = 4'h1;
    localparam logic [3:0] ADR_PRIO     = 4'h2;
    localparam logic [3:0] ADR_GRP_OR   = 4'h3;
    localparam logic [3:0] ADR_GRP_CLR  = 4'h4;

    localparam logic [3:0] IMASK_BLOCK_ALL = 4'hF;

endpackage

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
    import irq_agg_pkg::*;
#(
    parameter int N_SRC   = 8,
    parameter int FIELD_W = 4,
    parameter int N_GRP   = 2,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4,
    parameter int CNT_W   = 3,
    parameter logic [N_GRP-1:0][N_SRC-1:0] GRP_MAP = '0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_wr,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [DATA_W-1:0]             bus_rdata,
    output logic [N_SRC-1:0][CNT_W-1:0]   cnt_up,
    output logic [N_SRC-1:0][CNT_W-1:0]   cnt_dn
);

    localparam int PRIO_W = N_SRC * FIELD_W;

    logic [N_SRC-1:0]  mask_q, mask_nx;
    logic [PRIO_W-1:0] prio_q, prio_nx;
    logic [N_GRP-1:0]  grp_q, grp_nx;
    logic              unmapped;

    assign unmapped = (bus_addr > ADDR_W'(ADR_GRP_CLR));

    // next register values for the addressed write
    always_comb begin
        mask_nx = mask_q;
        prio_nx = prio_q;
        grp_nx  = grp_q;
        if (bus_wr) begin
            case (bus_addr)
                ADDR_W'(ADR_MASK_OR):  mask_nx = mask_q | bus_wdata[N_SRC-1:0];
                ADDR_W'(ADR_MASK_CLR): mask_nx = mask_q & ~bus_wdata[N_SRC-1:0];
                ADDR_W'(ADR_PRIO):     prio_nx = bus_wdata[PRIO_W-1:0];
                ADDR_W'(ADR_GRP_OR):   grp_nx  = grp_q | bus_wdata[N_GRP-1:0];
                ADDR_W'(ADR_GRP_CLR):  grp_nx  = grp_q & ~bus_wdata[N_GRP-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            prio_q <= '0;
            grp_q  <= '0;
        end else begin
            mask_q <= mask_nx;
            prio_q <= prio_nx;
            grp_q  <= grp_nx;
        end
    end

    // per-source enable count adjustments from fields that change state
    always_comb begin
        for (int i = 0; i < N_SRC; i++) begin
            logic was_on, now_on;
            cnt_up[i] = '0;
            cnt_dn[i] = '0;
            if (mask_q[N_SRC-1-i] != mask_nx[N_SRC-1-i]) begin
                if (mask_nx[N_SRC-1-i]) cnt_up[i] = cnt_up[i] + CNT_W'(1);
                else                    cnt_dn[i] = cnt_dn[i] + CNT_W'(1);
            end
            was_on = |prio_q[(N_SRC-1-i)*FIELD_W +: FIELD_W];
            now_on = |prio_nx[(N_SRC-1-i)*FIELD_W +: FIELD_W];
            if (was_on != now_on) begin
                if (now_on) cnt_up[i] = cnt_up[i] + CNT_W'(1);
                else        cnt_dn[i] = cnt_dn[i] + CNT_W'(1);
            end
            for (int g = 0; g < N_GRP; g++) begin
                if (GRP_MAP[g][i] && (grp_q[N_GRP-1-g] != grp_nx[N_GRP-1-g])) begin
                    if (grp_nx[N_GRP-1-g]) cnt_up[i] = cnt_up[i] + CNT_W'(1);
                    else                   cnt_dn[i] = cnt_dn[i] + CNT_W'(1);
                end
            end
        end
    end

    // read-back of the stored registers
    always_comb begin
        case (bus_addr)
            ADDR_W'(ADR_MASK_OR), ADDR_W'(ADR_MASK_CLR): bus_rdata = DATA_W'(mask_q);
            ADDR_W'(ADR_PRIO):                           bus_rdata = DATA_W'(prio_q);
            ADDR_W'(ADR_GRP_OR), ADDR_W'(ADR_GRP_CLR):   bus_rdata = DATA_W'(grp_q);
            default:                                     bus_rdata = '0;
        endcase
    end

    AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && unmapped) |=> ($stable(mask_q) && $stable(prio_q) && $stable(grp_q))); // R10

    AST_CLR_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(ADR_MASK_CLR)) |=> ((mask_q & ~$past(mask_q)) == '0)); // R3

endmodule

// File: rtl/irq_agg_enables.sv
module irq_agg_enables #(
    parameter int N_SRC = 8,
    parameter int N_GRP = 2,
    parameter int CNT_W = 3,
    parameter logic [N_GRP-1:0][N_SRC-1:0] GRP_MAP = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_SRC-1:0][CNT_W-1:0] cnt_up,
    input  logic [N_SRC-1:0][CNT_W-1:0] cnt_dn,
    output logic [N_SRC-1:0]            en_full
);

    function automatic int member_count(int idx);
        int c = 0;
        for (int g = 0; g < N_GRP; g++) begin
            if (GRP_MAP[g][idx]) c++;
        end
        return c;
    endfunction

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        // one mask bit, one priority field, plus every group holding the source
        localparam logic [CNT_W-1:0] EN_MAX = CNT_W'(2 + member_count(i));
        logic [CNT_W-1:0] cnt_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_q + cnt_up[i] - cnt_dn[i];
        end

        assign en_full[i] = (cnt_q == EN_MAX);

        AST_CNT_WITHIN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= EN_MAX); // R6
    end

endmodule

// File: rtl/irq_agg_vsel.sv
module irq_agg_vsel #(
    parameter int N_SRC    = 8,
    parameter int VEC_W    = 12,
    parameter int VEC_BASE = 'h400,
    parameter int VEC_STEP = 'h20
) (
    input  logic [N_SRC-1:0] pending,
    output logic             any_pend,
    output logic [VEC_W-1:0] sel_vec
);

    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    logic [IDX_W-1:0] sel_idx;

    // scan downward so the lowest index wins
    always_comb begin
        sel_idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pending[i]) sel_idx = IDX_W'(i);
        end
    end

    assign any_pend = |pending;
    assign sel_vec  = VEC_W'(VEC_BASE) + VEC_W'(int'(sel_idx) * VEC_STEP);

endmodule

// File: rtl/irq_source_aggregator.sv
module irq_source_aggregator
    import irq_agg_pkg::*;
#(
    parameter int N_SRC    = 8,
    parameter int FIELD_W  = 4,
    parameter int N_GRP    = 2,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4,
    parameter int VEC_W    = 12,
    parameter int VEC_BASE = 'h400,
    parameter int VEC_STEP = 'h20,
    parameter logic [N_GRP-1:0][N_SRC-1:0] GRP_MAP = {8'b1100_0000, 8'b0011_0000}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [3:0]        imask,
    output logic              cpu_irq,
    output logic [VEC_W-1:0]  vec_code,
    output logic              vec_valid
);

    localparam int CNT_W = $clog2(N_GRP + 3);

    logic [N_SRC-1:0][CNT_W-1:0] cnt_up, cnt_dn;
    logic [N_SRC-1:0]            en_full;
    logic [N_SRC-1:0]            src_q;
    logic [N_SRC-1:0]            pending;
    logic                        any_pend;
    logic [VEC_W-1:0]            sel_vec;
    line_state_e                 line_q, line_nx;

    irq_agg_regs #(
        .N_SRC(N_SRC), .FIELD_W(FIELD_W), .N_GRP(N_GRP), .DATA_W(DATA_W),
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .GRP_MAP(GRP_MAP)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_up(cnt_up), .cnt_dn(cnt_dn)
    );

    irq_agg_enables #(
        .N_SRC(N_SRC), .N_GRP(N_GRP), .CNT_W(CNT_W), .GRP_MAP(GRP_MAP)
    ) enables_i (
        .clk(clk), .rst_n(rst_n), .cnt_up(cnt_up), .cnt_dn(cnt_dn),
        .en_full(en_full)
    );

    // synchronous sampling of the level inputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_in;
    end

    assign pending = src_q & en_full;

    irq_agg_vsel #(
        .N_SRC(N_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
    ) vsel_i (
        .pending(pending), .any_pend(any_pend), .sel_vec(sel_vec)
    );

    // line machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= LINE_IDLE;
        else        line_q <= line_nx;
    end

    // line machine: transitions RAISE and DROP
    always_comb begin
        line_nx = line_q;
        unique case (line_q)
            LINE_IDLE:   if (any_pend)  line_nx = LINE_ACTIVE;
            LINE_ACTIVE: if (!any_pend) line_nx = LINE_IDLE;
            default:     line_nx = LINE_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_code  <= '0;
            vec_valid <= 1'b0;
        end else if (any_pend && (imask != IMASK_BLOCK_ALL)) begin
            vec_code  <= sel_vec;
            vec_valid <= 1'b1;
        end else begin
            vec_code  <= '0;
            vec_valid <= 1'b0;
        end
    end

    assign cpu_irq = (line_q == LINE_ACTIVE);

    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        any_pend |=> cpu_irq); // R7
    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !any_pend |=> !cpu_irq); // R7
    AST_VALID_WITH_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> cpu_irq); // R8
    AST_MASKED_NO_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (imask == IMASK_BLOCK_ALL) |=> (!vec_valid && vec_code == '0)); // R9

endmodule

// File: tb/irq_source_aggregator_tb.sv
`timescale 1ns/1ps
module irq_source_aggregator_tb_top;

    localparam int N_SRC = 8;
    localparam int FW    = 4;
    localparam int N_GRP = 2;
    localparam logic [N_GRP-1:0][N_SRC-1:0] GMAP = {8'b1100_0000, 8'b0011_0000};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  src_in = '0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  imask = '0;
    logic        cpu_irq;
    logic [11:0] vec_code;
    logic        vec_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0]  m_mask = '0;
    logic [31:0] m_prio = '0;
    logic [1:0]  m_grp  = '0;

    always #2.5 clk = ~clk;

    irq_source_aggregator dut_i (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .imask(imask), .cpu_irq(cpu_irq), .vec_code(vec_code), .vec_valid(vec_valid)
    );

    function automatic logic [7:0] exp_pending(logic [7:0] s);
        logic [7:0] p;
        for (int i = 0; i < N_SRC; i++) begin
            logic ok;
            ok = s[i] && m_mask[N_SRC-1-i] && (m_prio[(N_SRC-1-i)*FW +: FW] != 0);
            for (int g = 0; g < N_GRP; g++)
                if (GMAP[g][i] && !m_grp[N_GRP-1-g]) ok = 1'b0;
            p[i] = ok;
        end
        return p;
    endfunction

    function automatic logic [11:0] exp_vec(logic [7:0] p);
        for (int i = 0; i < N_SRC; i++)
            if (p[i]) return 12'h400 + 12'(i * 'h20);
        return 12'h000;
    endfunction

    function automatic logic [31:0] exp_read(logic [3:0] a);
        case (a)
            4'h0, 4'h1: return {24'h0, m_mask};
            4'h2:       return m_prio;
            4'h3, 4'h4: return {30'h0, m_grp};
            default:    return 32'h0;
        endcase
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic check_out(string req);
        logic [7:0] p;
        logic       v;
        p = exp_pending(src_in);
        v = (p != 0) && (imask != 4'hF);
        chk(req, "cpu_irq", 32'(cpu_irq), 32'(p != 0));
        chk(req, "vec_valid", 32'(vec_valid), 32'(v));
        chk(req, "vec_code", 32'(vec_code), v ? 32'(exp_vec(p)) : 32'h0);
    endtask

    task automatic check_read(string req, logic [3:0] a);
        bus_addr = a;
        #1;
        chk(req, "bus_rdata", bus_rdata, exp_read(a));
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        case (a)
            4'h0: m_mask = m_mask | d[7:0];
            4'h1: m_mask = m_mask & ~d[7:0];
            4'h2: m_prio = d;
            4'h3: m_grp  = m_grp | d[1:0];
            4'h4: m_grp  = m_grp & ~d[1:0];
            default: ;
        endcase
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "cpu_irq", 32'(cpu_irq), 0);
        chk("R1", "vec_valid", 32'(vec_valid), 0);
        chk("R1", "vec_code", 32'(vec_code), 0);
        for (int a = 0; a < 5; a++) check_read("R1", 4'(a));

        // R6 inputs high but nothing enabled
        src_in = 8'hFF; settle(); check_out("R6");

        // R2 set mask, R4 prio fields, sources 0..3 fully enabled
        wr(4'h0, 32'h0000_00FF); wr(4'h2, 32'h1111_1111); settle();
        check_out("R8"); check_read("R2", 4'h0);

        // R3 clear source 0 bit only
        wr(4'h1, 32'h0000_0080); settle();
        check_out("R3"); check_read("R3", 4'h1);
        chk("R3", "vec_code", 32'(vec_code), 32'h420);
        wr(4'h0, 32'h0000_0080); settle(); check_read("R2", 4'h0);

        // R4 nonzero-to-nonzero change on source 1, then to zero
        wr(4'h2, 32'h1F11_1111); settle(); check_out("R4");
        chk("R4", "vec_code", 32'(vec_code), 32'h400);
        wr(4'h2, 32'h0F11_1111); settle(); check_out("R4");
        chk("R4", "vec_code", 32'(vec_code), 32'h420);
        wr(4'h2, 32'h1111_1111); settle(); check_out("R4");
        check_read("R4", 4'h2);

        // R5 groups: only source 4 high
        src_in = 8'h10; settle(); check_out("R5");
        chk("R5", "cpu_irq", 32'(cpu_irq), 0);
        wr(4'h3, 32'h2); settle(); check_out("R5");
        chk("R5", "vec_code", 32'(vec_code), 32'h480);
        check_read("R5", 4'h3);
        wr(4'h4, 32'h2); settle(); check_out("R5");
        src_in = 8'hC0; wr(4'h3, 32'h1); settle(); check_out("R5");
        chk("R5", "vec_code", 32'(vec_code), 32'h4C0);

        // R9 imask 15 hides the vector but not the line
        imask = 4'hF; settle(); check_out("R9");
        chk("R9", "cpu_irq", 32'(cpu_irq), 1);
        imask = 4'h3; settle(); check_out("R9");

        // R10 unmapped write
        wr(4'hF, 32'hFFFF_FFFF); wr(4'h7, 32'h0); settle();
        check_out("R10"); check_read("R10", 4'hF); check_read("R10", 4'h5);
        for (int a = 0; a < 5; a++) check_read("R10", 4'(a));

        // R7 input timing: line follows two edges after input change
        src_in = 8'h00; settle(); check_out("R7");
        src_in = 8'h01;
        @(negedge clk); chk("R7", "cpu_irq early", 32'(cpu_irq), 0);
        @(negedge clk); chk("R7", "cpu_irq", 32'(cpu_irq), 1);
        chk("R7", "vec_code", 32'(vec_code), 32'h400);

        // R11 register write timing
        wr(4'h1, 32'h80);
        chk("R11", "cpu_irq early", 32'(cpu_irq), 1);
        @(negedge clk); chk("R11", "cpu_irq", 32'(cpu_irq), 0);

        // random mix
        for (int n = 0; n < 400; n++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 5)      wr(4'($urandom_range(0, 7)), $urandom);
            else if (op < 8) src_in = 8'($urandom);
            else             imask = 4'($urandom_range(13, 15));
            settle();
            check_out("R6");
            check_read("R2", 4'($urandom_range(0, 7)));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule